// File: doc/BRIEF.md
# Logarithmic Bimodal-Insertion Hit-Curve Estimator

This block sits beside one thread's sampled last-level-cache traffic and estimates how many hits that thread would get under bimodal insertion for every way count from 1 to `A`. Bimodal insertion is not a stack policy, so one recency stack cannot give the whole curve. The block keeps a tag-only shadow directory at each power-of-two associativity 2, 4, 8 up to `A`. Each directory follows the bimodal rule and counts its own hits. The value at one way comes from the companion recency profiler's first-position hit count, which the block samples on the interval pulse.

On every sampler-set access, all directories look up and update in parallel. When the interval pulse arrives, the measured points are captured and the counters restart. A sequential engine then walks the ways one per cycle and rebuilds the missing curve points by straight-line interpolation between neighbouring measured points. It uses only add, subtract and arithmetic shift. The access stream is valid/ready. While the engine runs, the block holds `acc_ready` low. A source may keep `acc_valid` and its payload asserted until ready returns. A transfer takes place only in a cycle where both are high. The curve is read through a combinational read port.

Top module: `bip_curve_estimator`

## Requirements
- R1: After reset `acc_ready` is 1 and every curve entry reads 0.
- R2: A directory of associativity 2^k (k = 1..log2 A) keeps a separate recency-ordered tag list per sampler set. An accepted access whose tag is in that list is a hit: its counter rises by one and the tag moves to the most-recent position, with the entries above it moving down by one.
- R3: On a miss, if all 5 bits of `rnd` are 0 the tag goes to the most-recent position and, when the set is full, the least-recent tag is dropped. Otherwise the tag goes to the lowest free position, or replaces the least-recent tag when the set is full. `rnd` applies to every directory alike.
- R4: Each hit counter saturates at 2^CNT_W-1 and does not wrap.
- R5: On `epoch`, the counter values from before that edge are captured and the counters restart. An access accepted in the `epoch` cycle counts in the new interval.
- R6: The curve value for one way equals `lru_hit1` as sampled in the `epoch` cycle.
- R7: At way count 2^k the curve equals the captured count of that directory. For lower point L = 2^(k-1), with values lo and hi, way L+j (0 < j < L) reads lo + j*floor((hi-lo)/L). A negative result reads 0.
- R8: The curve entry for way w (w = 1..A, read address w-1) takes its new value at the w-th clock edge after the edge that samples `epoch`. `acc_ready` is 0 from that edge through the A-th edge after it. An access offered while ready is 0 changes no directory and no counter.
- R9: An `epoch` while the fill is running restarts the fill from way 1 with the newly captured points. No write for the old fill happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Sampler-set access offered |
| acc_ready | output | 1 | Access accepted this cycle when high |
| acc_set | input | log2(SETS) | Sampler-set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| rnd | input | 5 | Pseudo-random bits; all zero selects most-recent insertion |
| epoch | input | 1 | Interval-boundary pulse |
| lru_hit1 | input | CNT_W | Recency profiler's first-position hit count |
| rd_way | input | log2(A) | Read address (way count minus one) |
| rd_hits | output | CNT_W | Curve value at `rd_way` |

## Verification
The bench builds the block with A = 8, SETS = 2, TAG_W = 4 and CNT_W = 6. With only two sets and sixteen tags, the 2-way and 4-way directories overflow after a handful of accesses, so both insertion modes meet full and part-full sets. The 6-bit counters make saturation reachable in under a hundred accesses. Three interpolated segments of gap 1, 2 and 4 exercise the zero, one and two position shifts. An 8-cycle fill leaves room to raise a second pulse mid-fill and to offer accesses against low ready.

// File: rtl/bipc_pkg.sv
package bipc_pkg;

  localparam int RND_W = 5;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 30; i++) begin
      if (v >= (1 << (i + 1))) r = i + 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/bipc_shadow_dir.sv
module bipc_shadow_dir
  import bipc_pkg::*;
#(
  parameter int WAYS  = 2,
  parameter int SETS  = 8,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_fire,
  input  logic [$clog2(SETS)-1:0] acc_set,
  input  logic [TAG_W-1:0]        acc_tag,
  input  logic [RND_W-1:0]        rnd,
  input  logic                    epoch,
  output logic [CNT_W-1:0]        hit_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [WAYS-1:0]  vld_q [SETS];

  logic [TAG_W-1:0] row_tag [WAYS];
  logic [WAYS-1:0]  row_vld;
  logic [TAG_W-1:0] nxt_tag [WAYS];
  logic [WAYS-1:0]  nxt_vld;
  logic             hit;
  logic             mru_ins;
  int               hit_pos;
  int               free_pos;

  // lookup in the addressed set; valid entries always form a prefix
  always_comb begin
    row_vld  = vld_q[acc_set];
    hit      = 1'b0;
    hit_pos  = 0;
    free_pos = WAYS - 1;
    for (int i = 0; i < WAYS; i++) row_tag[i] = tag_q[acc_set][i];
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (row_vld[i] && (row_tag[i] == acc_tag)) begin
        hit     = 1'b1;
        hit_pos = i;
      end
      if (!row_vld[i]) free_pos = i;
    end
    mru_ins = (rnd == '0);
  end

  // next row: promote on hit, else bimodal insertion
  always_comb begin
    nxt_vld = row_vld;
    for (int i = 0; i < WAYS; i++) nxt_tag[i] = row_tag[i];
    if (hit) begin
      nxt_tag[0] = acc_tag;
      for (int i = 1; i < WAYS; i++) begin
        if (i <= hit_pos) nxt_tag[i] = row_tag[i-1];
      end
    end else if (mru_ins) begin
      nxt_tag[0] = acc_tag;
      for (int i = 1; i < WAYS; i++) nxt_tag[i] = row_tag[i-1];
      nxt_vld = {row_vld[WAYS-2:0], 1'b1};
    end else begin
      for (int i = 0; i < WAYS; i++) begin
        if (i == free_pos) begin
          nxt_tag[i] = acc_tag;
          nxt_vld[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int i = 0; i < WAYS; i++) tag_q[s][i] <= '0;
      end
      hit_cnt <= '0;
    end else begin
      if (acc_fire) begin
        vld_q[acc_set] <= nxt_vld;
        for (int i = 0; i < WAYS; i++) tag_q[acc_set][i] <= nxt_tag[i];
      end
      if (epoch) begin
        hit_cnt <= (acc_fire && hit) ? CNT_W'(1) : '0;
      end else if (acc_fire && hit && (hit_cnt != CNT_MAX)) begin
        hit_cnt <= hit_cnt + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_chk
    // R3
    valid_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((vld_q[s] & (vld_q[s] + 1'b1)) == '0));
  end

  // R2
  mru_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && (hit || mru_ins) |=>
      (tag_q[$past(acc_set)][0] == $past(acc_tag)) && vld_q[$past(acc_set)][0]);

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch && (hit_cnt == CNT_MAX) |=> (hit_cnt == CNT_MAX));

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epoch && !(acc_fire && hit) |=> $stable(hit_cnt));

endmodule

// File: rtl/bipc_curve_fill.sv
module bipc_curve_fill
  import bipc_pkg::*;
#(
  parameter int A     = 16,
  parameter int CNT_W = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [$clog2(A):0][CNT_W-1:0]      pts,
  input  logic [$clog2(A)-1:0]               rd_idx,
  output logic                               busy,
  output logic [CNT_W-1:0]                   rd_val
);

  localparam int K     = $clog2(A);
  localparam int IDX_W = K;
  localparam int AW    = CNT_W + 2;

  logic [K:0][CNT_W-1:0] pts_q;
  logic [CNT_W-1:0]      curve_q [A];
  logic [IDX_W-1:0]      idx_q;
  logic signed [AW-1:0]  acc_q, step_q;
  logic signed [AW-1:0]  acc_nxt, step_nxt, lo_s, hi_s;
  logic [CNT_W-1:0]      wr_val;
  logic                  at_pt;
  int                    cur_w;
  int                    seg;

  always_comb begin
    cur_w = int'(idx_q) + 1;
    at_pt = is_pow2(cur_w);
    seg   = floor_log2(cur_w);
    lo_s  = '0;
    hi_s  = '0;
    for (int k = 0; k <= K; k++) begin
      if (k == seg)     lo_s = signed'({2'b00, pts_q[k]});
      if (k == seg + 1) hi_s = signed'({2'b00, pts_q[k]});
    end
    step_nxt = (hi_s - lo_s) >>> seg;
    acc_nxt  = at_pt ? lo_s : (acc_q + step_q);
    wr_val   = acc_nxt[AW-1] ? '0 : acc_nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx_q  <= '0;
      acc_q  <= '0;
      step_q <= '0;
      pts_q  <= '0;
      for (int i = 0; i < A; i++) curve_q[i] <= '0;
    end else if (start) begin
      pts_q <= pts;
      busy  <= 1'b1;
      idx_q <= '0;
    end else if (busy) begin
      curve_q[idx_q] <= wr_val;
      acc_q          <= acc_nxt;
      if (at_pt) step_q <= step_nxt;
      if (idx_q == IDX_W'(A - 1)) busy  <= 1'b0;
      else                        idx_q <= idx_q + 1'b1;
    end
  end

  assign rd_val = curve_q[rd_idx];

  // R8
  fill_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && (idx_q == IDX_W'(A - 1)) |=> !busy);

  // R9
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && (idx_q == '0));

  // R7
  no_neg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && acc_nxt[AW-1] |=> (curve_q[$past(idx_q)] == '0));

endmodule

// File: rtl/bip_curve_estimator.sv
module bip_curve_estimator
  import bipc_pkg::*;
#(
  parameter int A     = 16,
  parameter int SETS  = 8,
  parameter int TAG_W = 12,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_valid,
  output logic                    acc_ready,
  input  logic [$clog2(SETS)-1:0] acc_set,
  input  logic [TAG_W-1:0]        acc_tag,
  input  logic [RND_W-1:0]        rnd,
  input  logic                    epoch,
  input  logic [CNT_W-1:0]        lru_hit1,
  input  logic [$clog2(A)-1:0]    rd_way,
  output logic [CNT_W-1:0]        rd_hits
);

  localparam int K = $clog2(A);

  logic [K:0][CNT_W-1:0] pts;
  logic [CNT_W-1:0]      dir_cnt [1:K];
  logic                  fill_busy;
  logic                  acc_fire;

  assign acc_ready = !fill_busy;
  assign acc_fire  = acc_valid && acc_ready;

  for (genvar k = 1; k <= K; k++) begin : g_dir
    bipc_shadow_dir #(
      .WAYS (1 << k),
      .SETS (SETS),
      .TAG_W(TAG_W),
      .CNT_W(CNT_W)
    ) u_dir (
      .clk     (clk),
      .rst_n   (rst_n),
      .acc_fire(acc_fire),
      .acc_set (acc_set),
      .acc_tag (acc_tag),
      .rnd     (rnd),
      .epoch   (epoch),
      .hit_cnt (dir_cnt[k])
    );
  end

  always_comb begin
    pts[0] = lru_hit1;
    for (int k = 1; k <= K; k++) pts[k] = dir_cnt[k];
  end

  bipc_curve_fill #(
    .A    (A),
    .CNT_W(CNT_W)
  ) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .start (epoch),
    .pts   (pts),
    .rd_idx(rd_way),
    .busy  (fill_busy),
    .rd_val(rd_hits)
  );

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch |=> !acc_ready);

endmodule

// File: tb/bip_curve_estimator_tb.sv
module bip_curve_estimator_tb;

  localparam int A     = 8;
  localparam int SETS  = 2;
  localparam int TAG_W = 4;
  localparam int CNT_W = 6;
  localparam int K     = $clog2(A);
  localparam int SET_W = $clog2(SETS);
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             acc_valid = 1'b0;
  logic             acc_ready;
  logic [SET_W-1:0] acc_set = '0;
  logic [TAG_W-1:0] acc_tag = '0;
  logic [4:0]       rnd = '0;
  logic             epoch = 1'b0;
  logic [CNT_W-1:0] lru_hit1 = '0;
  logic [K-1:0]     rd_way = '0;
  logic [CNT_W-1:0] rd_hits;

  always #5 clk = ~clk;

  bip_curve_estimator #(.A(A), .SETS(SETS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_set(acc_set), .acc_tag(acc_tag), .rnd(rnd), .epoch(epoch),
    .lru_hit1(lru_hit1), .rd_way(rd_way), .rd_hits(rd_hits)
  );

  // reference model state
  int    dq [1:K][SETS][$];
  int    cnt [1:K];
  int    curve_m [A];
  int    pend [A];
  bit    filling;
  int    fpos;
  int    rd_ptr;
  int    vectors;
  int    misses;
  string cur_req;
  int unsigned seed = 32'h1234_5678;

  function automatic int nxt_rand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed >> 16);
  endfunction

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  task automatic compare();
    vectors++;
    if (acc_ready !== !filling) begin
      misses++;
      $display("FAIL R8 acc_ready got %0b exp %0b", acc_ready, !filling);
    end
    vectors++;
    if (rd_hits !== CNT_W'(curve_m[rd_ptr])) begin
      misses++;
      $display("FAIL %s rd_hits way %0d got %0d exp %0d",
               cur_req, rd_ptr + 1, rd_hits, curve_m[rd_ptr]);
    end
  endtask

  // one clock: drive at negedge, advance model, sample 2 ns after the edge
  task automatic cyc(input bit v, input int set, input int tag, input int r,
                     input bit ep, input int l1);
    int  saved [1:K];
    int  pts [0:K];
    bit  hk [1:K];
    bit  fire;
    acc_valid = v;
    acc_set   = set[SET_W-1:0];
    acc_tag   = tag[TAG_W-1:0];
    rnd       = r[4:0];
    epoch     = ep;
    lru_hit1  = l1[CNT_W-1:0];
    rd_way    = rd_ptr[K-1:0];
    fire = v && !filling;
    for (int k = 1; k <= K; k++) begin
      saved[k] = cnt[k];
      hk[k]    = 1'b0;
    end
    if (fire) begin
      for (int k = 1; k <= K; k++) begin
        int w;
        int p;
        w = 1 << k;
        p = -1;
        foreach (dq[k][set][i]) if (p < 0 && dq[k][set][i] == tag) p = i;
        if (p >= 0) begin
          hk[k] = 1'b1;
          dq[k][set].delete(p);
          dq[k][set].push_front(tag);
          if (cnt[k] < CMAX) cnt[k]++;
        end else if (r == 0) begin
          dq[k][set].push_front(tag);
          if (dq[k][set].size() > w) void'(dq[k][set].pop_back());
        end else if (dq[k][set].size() < w) begin
          dq[k][set].push_back(tag);
        end else begin
          dq[k][set][w-1] = tag;
        end
      end
    end
    if (ep) begin
      pts[0] = l1;
      for (int k = 1; k <= K; k++) begin
        pts[k] = saved[k];
        cnt[k] = hk[k] ? 1 : 0;
      end
      for (int k = 1; k <= K; k++) begin
        int gap;
        int stp;
        gap = 1 << (k - 1);
        stp = (pts[k] - pts[k-1]) >>> (k - 1);
        for (int j = 0; j < gap; j++) begin
          int val;
          val = pts[k-1] + j * stp;
          pend[gap - 1 + j] = (val < 0) ? 0 : val;
        end
        pend[(1 << k) - 1] = pts[k];
      end
      filling = 1'b1;
      fpos    = 0;
    end else if (filling) begin
      curve_m[fpos] = pend[fpos];
      fpos++;
      if (fpos == A) filling = 1'b0;
    end
    @(posedge clk);
    #2;
    compare();
    rd_ptr = (rd_ptr + 1) % A;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1, 1'b0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired got hung exp finished");
    summary();
    $finish;
  end

  initial begin
    for (int k = 1; k <= K; k++) cnt[k] = 0;
    for (int i = 0; i < A; i++) begin
      curve_m[i] = 0;
      pend[i] = 0;
    end
    filling = 1'b0;
    fpos = 0;
    rd_ptr = 0;
    vectors = 0;
    misses = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, ready high and curve zero on all ways
    idle(A + 2);

    // R2: hits promote to most-recent position and count
    cur_req = "R2";
    cyc(1, 0, 1, 3, 0, 0);
    cyc(1, 0, 2, 3, 0, 0);
    cyc(1, 0, 1, 3, 0, 0);
    cyc(1, 0, 2, 3, 0, 0);
    cyc(1, 1, 5, 3, 0, 0);
    cyc(1, 1, 5, 3, 0, 0);
    // R3: both insertion modes, full and part-full sets
    cur_req = "R3";
    cyc(1, 0, 3, 0, 0, 0);
    cyc(1, 0, 4, 7, 0, 0);
    cyc(1, 0, 1, 3, 0, 0);
    for (int i = 0; i < 80; i++) begin
      int x;
      int rr;
      x  = nxt_rand();
      rr = ((x % 3) == 0) ? 0 : 1 + ((x >> 4) % 31);
      cyc((x % 5) != 0, (x >> 2) % SETS, (x >> 8) % 7, rr, 0, 0);
    end
    // R6 and R7: capture, then R8 accesses against low ready
    cur_req = "R6";
    cyc(0, 0, 0, 1, 1, 7);
    cur_req = "R8";
    for (int i = 0; i < A; i++) cyc(1, 0, 1, 0, 0, 0);
    cur_req = "R7";
    idle(2 * A);

    // second interval with a larger way-1 value
    cur_req = "R3";
    for (int i = 0; i < 60; i++) begin
      int x;
      x = nxt_rand();
      cyc(1, x % SETS, (x >> 3) % 5, ((x >> 6) % 4 == 0) ? 0 : 9, 0, 0);
    end
    cur_req = "R6";
    cyc(0, 0, 0, 1, 1, 50);
    cur_req = "R7";
    idle(2 * A);

    // R4: saturation of every counter
    cur_req = "R4";
    cyc(1, 1, 9, 2, 0, 0);
    for (int i = 0; i < 75; i++) cyc(1, 1, 9, 2, 0, 0);
    cyc(0, 0, 0, 1, 1, 10);
    idle(2 * A);

    // R5: access in the pulse cycle counts in the new interval
    cur_req = "R5";
    cyc(1, 1, 9, 2, 1, 3);
    idle(A + 1);
    cyc(0, 0, 0, 1, 1, 4);
    idle(2 * A);

    // R9: second pulse while the fill is running
    cur_req = "R9";
    cyc(1, 0, 1, 1, 0, 0);
    cyc(1, 0, 1, 1, 0, 0);
    cyc(0, 0, 0, 1, 1, 20);
    idle(3);
    cyc(0, 0, 0, 1, 1, 33);
    idle(2 * A);

    summary();
    $finish;
  end

endmodule